// File: doc/BRIEF.md
# Parallel Additive Data Scrambler

This block whitens a data stream W bits at a time. It XORs each incoming word with a keystream drawn from a free-running 16-bit linear feedback shift register whose generator is x^16+x^5+x^4+x^3+1. The register runs on its own: its next value depends only on its present value and never on the data. Because of that, the same block undoes its own work. Give a second copy the same seed and feed it the scrambled words in the same order, and it returns the original data.

The serial model behind the block shifts one bit per step. The keystream bit of a step is state bit 15. The state then shifts left by one place and takes `s[15]^s[4]^s[3]^s[2]` into bit 0. Data bit 0 is the first bit in serial order. The parallel block applies W such steps in one clock. Two constant XOR matrices do the work: one maps the state to the state W steps later, the other maps the state to the W keystream bits. Both matrices are computed at elaboration by pushing one-hot states through the serial model.

Both edges are valid/ready streams. A word is taken when `in_valid` and `in_ready` are high at a rising clock edge. The result sits in one output register, and `out_valid` stays high until the consumer takes the word with `out_ready`. While `out_valid` is high and `out_ready` is low, the word holds steady and `in_ready` is low, so back-pressure reaches the producer in the same cycle.

Top module: `addscr_lane`

## Requirements
- R1: Synchronous active-high `rst` clears `out_valid` and loads the state with 16'hFFFF. With that seed, the first W keystream bits after reset are all ones for W up to 16, so an all-zero first word scrambles to all ones.
- R2: An accepted word appears as `in_data[t] ^ k[t]`, where k[t] is state bit 15 after t serial steps from the state held at acceptance. Bit t is the t-th serial bit, and each step shifts left and feeds `s[15]^s[4]^s[3]^s[2]` into bit 0.
- R3: The state advances by exactly W serial steps for each accepted word. Cycles with no acceptance leave it unchanged, so idle gaps do not shift the keystream.
- R4: `out_valid` is high in the cycle after an acceptance. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: The keystream depends only on how many words have been accepted since reset, never on the data values.
- R7: A second instance with the same seed, fed the scrambled stream, returns the original words in order.
- R8: The word width W is a parameter. The same rules hold at W=8 and at W=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | W | Word to scramble; bit 0 is first in serial order |
| out_valid | output | 1 | Scrambled word is held |
| out_ready | input | 1 | Consumer takes the held word |
| out_data | output | W | Scrambled word |

## Verification
A word accepted at one rising edge appears on `out_data` with `out_valid` one edge later. It stays there until the edge at which `out_ready` is high. `in_ready` follows `out_valid` and `out_ready` in the same cycle, with no register in between. The bench drives all inputs and samples all outputs just after the falling edge. At that point it records each handshake that the next rising edge will complete: expected scrambled words are queued when an input is taken and compared when an output is taken. This way the one-register latency and any stall length are covered without counting fixed delays. The chained descrambler is compared the same way, one stage further down the stream.

// File: rtl/addscr_pkg.sv
package addscr_pkg;
  localparam int unsigned SW = 16;
  localparam int unsigned MAXW = 64;
  localparam logic [SW-1:0] SEED_DEF = 16'hFFFF;

  // one serial step of x^16+x^5+x^4+x^3+1, shift left, feedback into bit 0
  function automatic logic [SW-1:0] lfsr_step(input logic [SW-1:0] s);
    return {s[SW-2:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
  endfunction

  // state bits that feed bit i of the state w steps later
  function automatic logic [SW-1:0] adv_row(input int i, input int w);
    logic [SW-1:0] row;
    logic [SW-1:0] s;
    row = '0;
    for (int j = 0; j < SW; j++) begin
      s = '0;
      s[j] = 1'b1;
      for (int t = 0; t < w; t++) s = lfsr_step(s);
      row[j] = s[i];
    end
    return row;
  endfunction

  // state bits that feed keystream bit i (taken after i steps)
  function automatic logic [SW-1:0] ks_row(input int i);
    logic [SW-1:0] row;
    logic [SW-1:0] s;
    row = '0;
    for (int j = 0; j < SW; j++) begin
      s = '0;
      s[j] = 1'b1;
      for (int t = 0; t < i; t++) s = lfsr_step(s);
      row[j] = s[SW-1];
    end
    return row;
  endfunction
endpackage

// File: rtl/addscr_advance.sv
module addscr_advance
  import addscr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [SW-1:0] cur,
  output logic [SW-1:0] nxt
);
  // R3: W serial steps folded into one XOR matrix
  for (genvar i = 0; i < SW; i++) begin : g_row
    localparam logic [SW-1:0] ROW = adv_row(i, W);
    assign nxt[i] = ^(cur & ROW);
  end
endmodule

// File: rtl/addscr_keystream.sv
module addscr_keystream
  import addscr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [SW-1:0] cur,
  output logic [W-1:0]  ks
);
  // R2, R6: keystream is a linear function of the state alone
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SW-1:0] ROW = ks_row(i);
    assign ks[i] = ^(cur & ROW);
  end
endmodule

// File: rtl/addscr_lane.sv
module addscr_lane
  import addscr_pkg::*;
#(
  parameter int            W    = 8,
  parameter logic [15:0]   SEED = SEED_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_nxt;
  logic [W-1:0]  ks;
  logic          take;

  addscr_advance #(.W(W)) u_adv (
    .cur (state_q),
    .nxt (state_nxt)
  );

  addscr_keystream #(.W(W)) u_ks (
    .cur (state_q),
    .ks  (ks)
  );

  // R5: single output slot, free when empty or being drained
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEED;            // R1
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      state_q   <= state_nxt;       // R3
      out_data  <= in_data ^ ks;    // R2
      out_valid <= 1'b1;            // R4
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/addscr_lane_chk.sv
module addscr_lane_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> !out_valid); // R1

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R5

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid); // R4
endmodule

bind addscr_lane addscr_lane_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/addscr_lane_bench.sv
module addscr_lane_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  // narrow scrambler chained into a descrambler
  logic       a_iv = 1'b0, a_ir, a_ov;
  logic [7:0] a_id = '0, a_od;
  logic       d_ir, d_ov, d_or = 1'b1;
  logic [7:0] d_od;
  // wide scrambler
  logic        w_iv = 1'b0, w_ir, w_ov, w_or = 1'b1;
  logic [31:0] w_id = '0, w_od;

  addscr_lane #(.W(8)) u_addscr_lane (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir), .in_data(a_id),
    .out_valid(a_ov), .out_ready(d_ir), .out_data(a_od));

  addscr_lane #(.W(8)) u_descr (
    .clk(clk), .rst(rst), .in_valid(a_ov), .in_ready(d_ir), .in_data(a_od),
    .out_valid(d_ov), .out_ready(d_or), .out_data(d_od));

  addscr_lane #(.W(32)) u_wide (
    .clk(clk), .rst(rst), .in_valid(w_iv), .in_ready(w_ir), .in_data(w_id),
    .out_valid(w_ov), .out_ready(w_or), .out_data(w_od));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] st_a, st_w;
  logic [7:0]  qa_exp[$], qa_pln[$], qd_exp[$];
  logic [31:0] qw_exp[$];
  bit first_a, first_w;
  bit hold_a, hold_w;
  logic [7:0]  held_a;
  logic [31:0] held_w;

  function automatic logic [15:0] m_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
  endfunction

  function automatic logic [31:0] m_ks(input logic [15:0] s0, input int w);
    logic [15:0] s = s0;
    logic [31:0] k = '0;
    for (int t = 0; t < w; t++) begin
      k[t] = s[15];
      s = m_step(s);
    end
    return k;
  endfunction

  function automatic logic [15:0] m_adv(input logic [15:0] s0, input int w);
    logic [15:0] s = s0;
    for (int t = 0; t < w; t++) s = m_step(s);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    st_a = 16'hFFFF; st_w = 16'hFFFF;
    qa_exp.delete(); qa_pln.delete(); qd_exp.delete(); qw_exp.delete();
    first_a = 1'b1; first_w = 1'b1; hold_a = 1'b0; hold_w = 1'b0;
  endtask

  // one cycle: drive at falling edge, then record the handshakes of the next rise
  task automatic cycle(input int vpct, input int rpct, input bit zero);
    logic [7:0] pl, ex;
    @(negedge clk);
    // R4: a stalled word must still be there, unchanged
    if (hold_a) chk(a_ov && a_od == held_a, "R4 narrow hold", {23'd0, a_ov, a_od}, {24'd1, held_a});
    if (hold_w) chk(w_ov && w_od == held_w, "R4 wide hold", w_od, held_w);
    a_iv = ($urandom % 100) < vpct;
    a_id = zero ? 8'h00 : 8'($urandom);
    d_or = ($urandom % 100) < rpct;
    w_iv = ($urandom % 100) < vpct;
    w_id = zero ? 32'h0 : $urandom;
    w_or = ($urandom % 100) < rpct;
    #1;
    // R5: ready rule on all three stages
    chk(a_ir == (!a_ov || d_ir), "R5 narrow ready", {31'd0, a_ir}, {31'd0, (!a_ov || d_ir)});
    chk(d_ir == (!d_ov || d_or), "R5 descr ready", {31'd0, d_ir}, {31'd0, (!d_ov || d_or)});
    chk(w_ir == (!w_ov || w_or), "R5 wide ready", {31'd0, w_ir}, {31'd0, (!w_ov || w_or)});
    hold_a = a_ov && !d_ir; held_a = a_od;
    hold_w = w_ov && !w_or; held_w = w_od;
    // descrambler output taken: R7 must give back the plain word
    if (d_ov && d_or) begin
      ex = qd_exp.pop_front();
      chk(d_od == ex, "R7 descramble", {24'd0, d_od}, {24'd0, ex});
    end
    // narrow scrambler output taken (also the descrambler's input)
    if (a_ov && d_ir) begin
      ex = qa_exp.pop_front();
      pl = qa_pln.pop_front();
      chk(a_od == ex, "R2 R3 R6 narrow word", {24'd0, a_od}, {24'd0, ex});
      if (first_a && pl == 8'h00)
        chk(a_od == 8'hFF, "R1 narrow first word", {24'd0, a_od}, 32'hFF);
      first_a = 1'b0;
      qd_exp.push_back(pl);
    end
    if (w_ov && w_or) begin
      chk(w_od == qw_exp[0], "R2 R3 R8 wide word", w_od, qw_exp[0]);
      if (first_w) chk(w_od[15:0] == 16'hFFFF, "R1 wide first word", w_od, 32'hFFFF);
      first_w = 1'b0;
      void'(qw_exp.pop_front());
    end
    // inputs taken: compute expected from the serial model (R2, R3)
    if (a_iv && a_ir) begin
      qa_exp.push_back(a_id ^ 8'(m_ks(st_a, 8)));
      qa_pln.push_back(a_id);
      st_a = m_adv(st_a, 8);
    end
    if (w_iv && w_ir) begin
      qw_exp.push_back(w_id ^ m_ks(st_w, 32));
      st_w = m_adv(st_w, 32);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_iv = 1'b0; w_iv = 1'b0; d_or = 1'b1; w_or = 1'b1;
    repeat (3) @(negedge clk);
    chk(!a_ov && !d_ov && !w_ov, "R1 valid low in reset", {29'd0, a_ov, d_ov, w_ov}, 32'd0);
    model_reset();
    rst = 1'b0;
    #1;
    chk(a_ir && w_ir, "R5 ready after reset", {30'd0, a_ir, w_ir}, 32'd3);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    do_reset();
    // directed: zero word first, all ready (R1)
    cycle(100, 100, 1'b1);
    cycle(0, 100, 1'b0);
    // R3: long idle gap, keystream must resume where it stopped
    repeat (20) cycle(0, 100, 1'b0);
    repeat (10) cycle(100, 100, 1'b1);   // R6: zero data shows raw keystream
    repeat (600) cycle(70, 60, 1'b0);
    repeat (400) cycle(100, 20, 1'b0);   // heavy back-pressure (R4)
    repeat (400) cycle(30, 100, 1'b0);   // sparse input (R3)
    repeat (20) cycle(0, 100, 1'b0);
    // mid-run reset must reload the seed (R1)
    do_reset();
    cycle(100, 0, 1'b1);
    repeat (3) cycle(0, 0, 1'b0);        // stall the first word (R4)
    repeat (600) cycle(80, 80, 1'b0);
    repeat (20) cycle(0, 100, 1'b0);
    chk(qa_exp.size() == 0 && qd_exp.size() == 0 && qw_exp.size() == 0,
        "R7 R8 all words delivered", qa_exp.size() + qd_exp.size() + qw_exp.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, no requirement completed");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule